// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Register Block

This block holds the seconds count of a real-time clock and presents it to software through a small memory-mapped register window. It has a 32-bit data bus with a byte address, a write enable and a combinational read port. A separate tick generator supplies a one-second strobe and its live sub-second count. Oscillator, battery switchover and tick generation sit outside this block. This block keeps only the counters, the compare register and the controls those neighbours consume.

Software sets the time by writing a staging register. The value can be read back at once, but it enters the running seconds counter only on the next one-second strobe. A 32-bit alarm register is compared with the running count. Two event bits, one for seconds and one for alarm, are cleared by writing ones. A mask is edited through separate set and clear strobe offsets, and a single interrupt line is the OR of every pending event whose mask bit is set. The control register drives the oscillator-enable and battery-switch-enable outputs. A calibration value is stored here, handed to the tick generator, and announced with a one-cycle load pulse.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset the current time (0x10), staging readback (0x04), alarm (0x18), mask (0x24), control (0x40) and calibration readback (0x0C) read zero, the seconds event bit is clear, and no load is pending.
- R2: A write to offset 0x00 is readable at 0x04 on the next cycle, and the current time at 0x10 stays unchanged until the next one-second strobe.
- R3: A one-second strobe while a staged value is pending copies that value into the current time and clears the pending state.
- R4: A one-second strobe with nothing pending adds one to the current time, wrapping from 0xFFFFFFFF to 0.
- R5: Event bit 0 at offset 0x20 is set on every one-second strobe, including the strobe that loads a staged value.
- R6: At offset 0x20, writing 1 to a bit clears it and writing 0 leaves it as it is. An event arriving in the same cycle as its clear leaves the bit set.
- R7: Event bit 1 at 0x20 is set in every cycle in which the current time equals the alarm register, so it sets again right after a clear while the two stay equal. With both at zero after reset, it sets in the first cycle.
- R8: Writing 1 to bit i at 0x28 sets mask bit i, and writing 1 to bit i at 0x2C clears it. Zero bits have no effect, and the result reads at 0x24 bits 1:0.
- R9: irq_o is high exactly when some event bit and its mask bit are both 1. Event bits set regardless of the mask.
- R10: Control offset 0x40 stores bit 24 (drives osc_en_o) and bit 31 (drives batt_en_o). All other bits read zero.
- R11: A write to 0x08 stores its low 21 bits. The stored value reads at 0x0C and drives calib_o, and calib_load_o is high for the one cycle after the write.
- R12: Offset 0x14 returns tick_cnt_i in bits 15:0 with the upper bits zero. The write-only offsets 0x00, 0x08, 0x28 and 0x2C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_strobe_i | input | 1 | One-cycle pulse at each second boundary |
| tick_cnt_i | input | 16 | Live sub-second tick count |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for addr_i/wdata_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt line |
| osc_en_o | output | 1 | Oscillator enable |
| batt_en_o | output | 1 | Battery switch enable |
| calib_o | output | 21 | Calibration value for the tick generator |
| calib_load_o | output | 1 | One-cycle pulse after a calibration write |

## Verification
Software acknowledges an event bit with a write-one clear, and the hardware can set the same bit in that same cycle. The bench creates this case twice. It raises the one-second strobe in the cycle of the clear of bit 0, and it clears bit 1 while the current time still equals the alarm. In both cases the bit must read back as set afterwards. A clear issued alone must leave the bit at zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned NSRC    = 2;
  localparam int unsigned SRC_SEC = 0;
  localparam int unsigned SRC_ALM = 1;

  // byte offsets decoded by software
  localparam int unsigned OFF_SET_WR = 'h00;
  localparam int unsigned OFF_SET_RD = 'h04;
  localparam int unsigned OFF_CAL_WR = 'h08;
  localparam int unsigned OFF_CAL_RD = 'h0C;
  localparam int unsigned OFF_CUR    = 'h10;
  localparam int unsigned OFF_TICK   = 'h14;
  localparam int unsigned OFF_ALM    = 'h18;
  localparam int unsigned OFF_STS    = 'h20;
  localparam int unsigned OFF_MASK   = 'h24;
  localparam int unsigned OFF_EN     = 'h28;
  localparam int unsigned OFF_DIS    = 'h2C;
  localparam int unsigned OFF_CTRL   = 'h40;

  localparam int unsigned CTRL_OSC_BIT  = 24;
  localparam int unsigned CTRL_BATT_BIT = 31;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sec_strobe_i,
  input  logic          set_we_i,
  input  logic          alarm_we_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] set_val_o,
  output logic [TW-1:0] cur_time_o,
  output logic [TW-1:0] alarm_o,
  output logic          pending_o,
  output logic          alarm_hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_val_o <= '0;
      pending_o <= 1'b0;
    end else if (set_we_i) begin
      set_val_o <= wdata_i;
      pending_o <= 1'b1;
    end else if (sec_strobe_i) begin
      pending_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cur_time_o <= '0;
    else if (sec_strobe_i) cur_time_o <= pending_o ? set_val_o : cur_time_o + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         alarm_o <= '0;
    else if (alarm_we_i) alarm_o <= wdata_i;
  end

  assign alarm_hit_o = (cur_time_o == alarm_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic            dis_we_i,
  input  logic [NSRC-1:0] wbits_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_o[i] <= 1'b0;
      else         status_o[i] <= (status_o[i] & ~(clr_we_i & wbits_i[i])) | evt_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     mask_o[i] <= 1'b0;
      else if (en_we_i && wbits_i[i])  mask_o[i] <= 1'b1;
      else if (dis_we_i && wbits_i[i]) mask_o[i] <= 1'b0;
    end
  end

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
  import rtc_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [TICK_W-1:0] tick_cnt_i,
  input  logic [DW-1:0]     cur_time_i,
  input  logic [DW-1:0]     set_val_i,
  input  logic [DW-1:0]     alarm_i,
  input  logic [NSRC-1:0]   status_i,
  input  logic [NSRC-1:0]   mask_i,
  output logic              set_we_o,
  output logic              alarm_we_o,
  output logic              clr_we_o,
  output logic              en_we_o,
  output logic              dis_we_o,
  output logic [DW-1:0]     rdata_o,
  output logic              osc_en_o,
  output logic              batt_en_o,
  output logic [CAL_W-1:0]  calib_o,
  output logic              calib_load_o
);
  localparam logic [AW-1:0] A_SET_WR = AW'(OFF_SET_WR);
  localparam logic [AW-1:0] A_SET_RD = AW'(OFF_SET_RD);
  localparam logic [AW-1:0] A_CAL_WR = AW'(OFF_CAL_WR);
  localparam logic [AW-1:0] A_CAL_RD = AW'(OFF_CAL_RD);
  localparam logic [AW-1:0] A_CUR    = AW'(OFF_CUR);
  localparam logic [AW-1:0] A_TICK   = AW'(OFF_TICK);
  localparam logic [AW-1:0] A_ALM    = AW'(OFF_ALM);
  localparam logic [AW-1:0] A_STS    = AW'(OFF_STS);
  localparam logic [AW-1:0] A_MASK   = AW'(OFF_MASK);
  localparam logic [AW-1:0] A_EN     = AW'(OFF_EN);
  localparam logic [AW-1:0] A_DIS    = AW'(OFF_DIS);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFF_CTRL);

  logic cal_we, ctrl_we;

  assign set_we_o   = wr_en_i && (addr_i == A_SET_WR);
  assign alarm_we_o = wr_en_i && (addr_i == A_ALM);
  assign clr_we_o   = wr_en_i && (addr_i == A_STS);
  assign en_we_o    = wr_en_i && (addr_i == A_EN);
  assign dis_we_o   = wr_en_i && (addr_i == A_DIS);
  assign cal_we     = wr_en_i && (addr_i == A_CAL_WR);
  assign ctrl_we    = wr_en_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_en_o  <= 1'b0;
      batt_en_o <= 1'b0;
    end else if (ctrl_we) begin
      osc_en_o  <= wdata_i[CTRL_OSC_BIT];
      batt_en_o <= wdata_i[CTRL_BATT_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      calib_o      <= '0;
      calib_load_o <= 1'b0;
    end else begin
      calib_load_o <= cal_we;
      if (cal_we) calib_o <= wdata_i[CAL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SET_RD: rdata_o = set_val_i;
      A_CAL_RD: rdata_o = DW'(calib_o);
      A_CUR:    rdata_o = cur_time_i;
      A_TICK:   rdata_o = DW'(tick_cnt_i);
      A_ALM:    rdata_o = alarm_i;
      A_STS:    rdata_o = DW'(status_i);
      A_MASK:   rdata_o = DW'(mask_i);
      A_CTRL: begin
        rdata_o[CTRL_OSC_BIT]  = osc_en_o;
        rdata_o[CTRL_BATT_BIT] = batt_en_o;
      end
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_strobe_i,
  input  logic [TICK_W-1:0] tick_cnt_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              osc_en_o,
  output logic              batt_en_o,
  output logic [CAL_W-1:0]  calib_o,
  output logic              calib_load_o
);
  logic [DW-1:0]   cur_time, set_val, alarm_val;
  logic            pending, alarm_hit;
  logic            set_we, alarm_we, clr_we, en_we, dis_we;
  logic [NSRC-1:0] status, mask, evt;

  rtc_time_core #(.TW(DW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sec_strobe_i(sec_strobe_i),
    .set_we_i    (set_we),
    .alarm_we_i  (alarm_we),
    .wdata_i     (wdata_i),
    .set_val_o   (set_val),
    .cur_time_o  (cur_time),
    .alarm_o     (alarm_val),
    .pending_o   (pending),
    .alarm_hit_o (alarm_hit)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_SEC] = sec_strobe_i;
    evt[SRC_ALM] = alarm_hit;
  end

  rtc_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_we_i(clr_we),
    .en_we_i (en_we),
    .dis_we_i(dis_we),
    .wbits_i (wdata_i[NSRC-1:0]),
    .status_o(status),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  rtc_reg_file #(.AW(AW), .TICK_W(TICK_W), .CAL_W(CAL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .tick_cnt_i  (tick_cnt_i),
    .cur_time_i  (cur_time),
    .set_val_i   (set_val),
    .alarm_i     (alarm_val),
    .status_i    (status),
    .mask_i      (mask),
    .set_we_o    (set_we),
    .alarm_we_o  (alarm_we),
    .clr_we_o    (clr_we),
    .en_we_o     (en_we),
    .dis_we_o    (dis_we),
    .rdata_o     (rdata_o),
    .osc_en_o    (osc_en_o),
    .batt_en_o   (batt_en_o),
    .calib_o     (calib_o),
    .calib_load_o(calib_load_o)
  );
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sec_strobe_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] cur_time,
  input logic [DW-1:0] set_val,
  input logic [DW-1:0] alarm_val,
  input logic          pending,
  input logic          set_we,
  input logic          clr_we,
  input logic          en_we,
  input logic          dis_we,
  input logic [1:0]    status,
  input logic [1:0]    mask,
  input logic          osc_en_o,
  input logic          batt_en_o,
  input logic [7:0]    addr_i,
  input logic          wr_en_i
);
  // R2
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_strobe_i |=> $stable(cur_time));
  // R2
  set_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we |=> (set_val == $past(wdata_i)) && pending);
  // R3
  set_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_strobe_i && pending && !set_we) |=> (cur_time == $past(set_val)) && !pending);
  // R4
  sec_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_strobe_i && !pending) |=> cur_time == $past(cur_time) + 1);
  // R5
  sec_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_strobe_i |=> status[0]);
  // R6
  sec_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && wdata_i[0] && !sec_strobe_i) |=> !status[0]);
  // R7
  alarm_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_time == alarm_val) |=> status[1]);
  // R8
  mask_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we && wdata_i[1]) |=> mask[1]);
  // R8
  mask_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_we && wdata_i[1]) |=> !mask[1]);
  // R10
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h40) |=> (osc_en_o == $past(wdata_i[24])) && (batt_en_o == $past(wdata_i[31])));
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.DW(32)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_strobe_i(sec_strobe_i),
  .wdata_i     (wdata_i),
  .cur_time    (cur_time),
  .set_val     (set_val),
  .alarm_val   (alarm_val),
  .pending     (pending),
  .set_we      (set_we),
  .clr_we      (clr_we),
  .en_we       (en_we),
  .dis_we      (dis_we),
  .status      (status),
  .mask        (mask),
  .osc_en_o    (osc_en_o),
  .batt_en_o   (batt_en_o),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i)
);

// File: tb/rtc_timekeeper_test.sv
module rtc_timekeeper_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_strobe_i = 1'b0;
  logic [15:0] tick_cnt_i = '0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, osc_en_o, batt_en_o, calib_load_o;
  logic [20:0] calib_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_time;
  logic [31:0] rv;

  always #2.5 clk_i = ~clk_i;

  rtc_timekeeper uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_strobe_i(sec_strobe_i), .tick_cnt_i(tick_cnt_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .osc_en_o(osc_en_o), .batt_en_o(batt_en_o),
    .calib_o(calib_o), .calib_load_o(calib_load_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i);
    sec_strobe_i = 1'b1;
    @(negedge clk_i);
    sec_strobe_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(); idle();

    // R1 reset values
    rd(8'h10, rv); chk("R1 cur", rv, 0);
    rd(8'h04, rv); chk("R1 setrd", rv, 0);
    rd(8'h18, rv); chk("R1 alarm", rv, 0);
    rd(8'h24, rv); chk("R1 mask", rv, 0);
    rd(8'h40, rv); chk("R1 ctrl", rv, 0);
    rd(8'h0C, rv); chk("R1 calib", rv, 0);
    // R7 alarm matches 0==0 from the first cycle
    rd(8'h20, rv); chk("R7 reset match", rv, 32'h2);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R12 tick readback and write-only offsets
    tick_cnt_i = 16'hA5C3;
    rd(8'h14, rv); chk("R12 tick", rv, 32'h0000A5C3);
    foreach (rv[i]) if (i < 1) begin end
    rd(8'h00, rv); chk("R12 wo 00", rv, 0);
    rd(8'h08, rv); chk("R12 wo 08", rv, 0);
    rd(8'h28, rv); chk("R12 wo 28", rv, 0);
    rd(8'h2C, rv); chk("R12 wo 2C", rv, 0);

    // move alarm away and clear events
    wr(8'h18, 32'hFFFF_FFF0);
    wr(8'h20, 32'h3);
    rd(8'h20, rv); chk("R6 clear both", rv, 0);

    // R2 staging
    wr(8'h00, 32'd100);
    rd(8'h04, rv); chk("R2 setrd", rv, 32'd100);
    rd(8'h10, rv); chk("R2 cur unchanged", rv, 0);
    idle(); idle();
    rd(8'h10, rv); chk("R2 cur still", rv, 0);
    // R3 load, R5 event on load
    tick();
    rd(8'h10, rv); chk("R3 load", rv, 32'd100);
    rd(8'h20, rv); chk("R5 evt on load", rv & 32'h1, 32'h1);
    // R4 increment
    tick(); exp_time = 32'd101;
    rd(8'h10, rv); chk("R4 incr", rv, exp_time);

    // R6 write 0 keeps, write 1 clears
    wr(8'h20, 32'h0);
    rd(8'h20, rv); chk("R6 write0 keeps", rv, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, rv); chk("R6 write1 clears", rv, 32'h0);
    // R6 collision: strobe in same cycle as clear
    @(negedge clk_i);
    addr_i = 8'h20; wdata_i = 32'h1; wr_en_i = 1'b1; sec_strobe_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; sec_strobe_i = 1'b0; wdata_i = '0;
    exp_time++;
    rd(8'h20, rv); chk("R6 event wins", rv & 32'h1, 32'h1);
    wr(8'h20, 32'h1);

    // R7 alarm sweep; clear right after each strobe
    wr(8'h18, exp_time + 32'd3);
    for (int k = 1; k <= 5; k++) begin
      tick(); exp_time++;
      wr(8'h20, 32'h2);
      rd(8'h20, rv);
      chk("R7 alarm sweep", (rv >> 1) & 32'h1, (exp_time == (32'd102 + 32'd3)) ? 32'h1 : 32'h0);
      rd(8'h10, rv); chk("R4 sweep time", rv, exp_time);
    end

    // R8 enable/disable sweep
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 4; d++) begin
        wr(8'h2C, 32'h3);
        wr(8'h28, 32'(e));
        rd(8'h24, rv); chk("R8 enable", rv, 32'(e));
        wr(8'h2C, 32'(d));
        rd(8'h24, rv); chk("R8 disable", rv, 32'(e & ~d & 3));
      end
    end

    // R9 interrupt combination
    tick(); exp_time++;
    wr(8'h18, exp_time);
    idle();
    rd(8'h20, rv); chk("R9 status both", rv, 32'h3);
    for (int m = 0; m < 4; m++) begin
      wr(8'h2C, 32'h3);
      wr(8'h28, 32'(m));
      #0.5;
      chk("R9 irq both", {31'b0, irq_o}, (m != 0) ? 1 : 0);
    end
    wr(8'h20, 32'h1);
    rd(8'h20, rv); chk("R9 status alarm only", rv, 32'h2);
    for (int m = 0; m < 4; m++) begin
      wr(8'h2C, 32'h3);
      wr(8'h28, 32'(m));
      #0.5;
      chk("R9 irq alarm", {31'b0, irq_o}, 32'((m >> 1) & 1));
    end
    wr(8'h2C, 32'h3);

    // R10 control
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, rv); chk("R10 ctrl all", rv, 32'h8100_0000);
    chk("R10 pins", {30'b0, batt_en_o, osc_en_o}, 32'h3);
    wr(8'h40, 32'h0100_0000);
    rd(8'h40, rv); chk("R10 ctrl osc", rv, 32'h0100_0000);
    chk("R10 pins osc", {30'b0, batt_en_o, osc_en_o}, 32'h1);

    // R11 calibration
    @(negedge clk_i);
    addr_i = 8'h08; wdata_i = 32'hFFF9_8233; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
    chk("R11 load pulse", {31'b0, calib_load_o}, 1);
    rd(8'h0C, rv); chk("R11 readback", rv, 32'h0019_8233);
    chk("R11 calib_o", {11'b0, calib_o}, 32'h0019_8233);
    idle();
    chk("R11 pulse ends", {31'b0, calib_load_o}, 0);

    // R4 wrap
    wr(8'h00, 32'hFFFF_FFFF);
    tick();
    rd(8'h10, rv); chk("R4 load max", rv, 32'hFFFF_FFFF);
    tick();
    rd(8'h10, rv); chk("R4 wrap", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule